// File: doc/BRIEF.md
# Programmable-Level Interrupt Priority Controller

This block takes in one request line per interrupt source and gives each source a programmable three-bit priority level. It holds a fixed number of sources, and each source owns an even vector address. Every cycle it finds the strongest eligible request. A request is eligible when its line is high, its level is nonzero, its level is strictly above the level the CPU is currently running at, and the CPU's global mask bit is clear. The winner is offered to the CPU as a registered vector address and level.

Levels are programmed through a windowed pair of registers. A window register holds the upper nibble of a vector address and so selects a group of eight sources. An eight-entry data window then gives access to that group's levels, where entry k stands for vector offset 2*k inside the group. The offered interrupt uses a valid/ready handshake. When valid and ready are both high at a clock edge, the controller drops valid for exactly one cycle. It also pulses a strobe carrying the accepted level, and the CPU side can load this level as its new current level.

Back-pressure rule: the offer is not sticky. While valid is high and ready is low, the vector and level follow the current winner with one cycle of delay, so a stronger request that arrives can replace a weaker one. The consumer takes whatever payload is present in the cycle it raises ready.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every source level reads 1, the window register reads 0x00, and irq_valid_o is low.
- R2: A source whose level is 0 is never offered, even while its request line is high.
- R3: Among eligible requests, the one with the greatest level wins, whatever its vector address.
- R4: When several eligible requests share the greatest level, the one with the higher vector address wins.
- R5: A request whose level is less than or equal to cur_level_i is not eligible.
- R6: While imask_i is high, no request is offered.
- R7: A write with cfg_sel_i=0 stores cfg_wdata_i[7:4] as the group number. Bits 3:0 of the window register always read 0. If the group number is NUM_GROUPS or more, data-window writes are ignored and data-window reads return 0.
- R8: A write with cfg_sel_i=1 stores cfg_wdata_i[2:0] as the level of the source at vector address {group, cfg_idx_i, 0}. A data-window read returns that level in bits 2:0 and zeros in bits 7:3.
- R9: irq_valid_o, irq_vector_o and irq_level_o show the winner for the inputs present before the preceding clock edge. The vector of source i is 2*i.
- R10: After an edge at which irq_valid_o and irq_ready_i are both high, irq_valid_o is low for one cycle, and then it follows the winner again.
- R11: The cycle after a handshake, ack_stb_o is high and ack_level_o equals the level that was accepted. In all other cycles ack_stb_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req_i | input | 8*NUM_GROUPS | Request line per source; bit i has vector 2*i |
| cur_level_i | input | 3 | Level the CPU currently runs at |
| imask_i | input | 1 | Global mask; blocks all requests when high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: window register, 1: data window |
| cfg_idx_i | input | 3 | Data-window entry within the group |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (combinational) |
| irq_valid_o | output | 1 | Interrupt offered |
| irq_ready_i | input | 1 | CPU accepts the offered interrupt |
| irq_vector_o | output | 8 | Vector address of the offer |
| irq_level_o | output | 3 | Level of the offer |
| ack_stb_o | output | 1 | One-cycle pulse after a handshake |
| ack_level_o | output | 3 | Level accepted at the last handshake |

## Verification
The bench first raises each request line alone. This separates the vector encoding and the gating of level-0 sources from the arbitration itself. It then drives many hashed multi-request patterns against a scattered level map, which tests level dominance across groups. After that it sets all levels equal, so only the tie-break by address decides, and it sweeps cur_level_i from 0 to 7 to find the exact strict-inequality boundary of masking. A handshake sequence and writes to windows that are out of range or carry stray bits cover the two edges of the block that are not arbitration.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int LVL_W  = 3;
  localparam int GRP_SZ = 8;
  localparam int CFG_W  = 8;
  typedef logic [LVL_W-1:0] level_t;
  localparam level_t LVL_RESET = level_t'(1);
endpackage

// File: rtl/ipc_level_bank.sv
module ipc_level_bank
  import ipc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int NSRC  = NUM_GROUPS * GRP_SZ,
  localparam int SEL_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [2:0]               cfg_idx,
  input  logic [CFG_W-1:0]         cfg_wdata,
  output logic [CFG_W-1:0]         cfg_rdata,
  output level_t [NSRC-1:0]        levels
);
  logic [3:0]       win_grp;
  logic             grp_ok;
  logic [SEL_W-1:0] sel_idx;

  assign grp_ok  = (int'(win_grp) < NUM_GROUPS);
  assign sel_idx = {win_grp, cfg_idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_grp <= '0;
    else if (cfg_we && !cfg_sel) win_grp <= cfg_wdata[7:4];
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar e = 0; e < GRP_SZ; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) levels[g*GRP_SZ+e] <= LVL_RESET;
        else if (cfg_we && cfg_sel && win_grp == 4'(g) && cfg_idx == 3'(e))
          levels[g*GRP_SZ+e] <= cfg_wdata[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_sel) cfg_rdata = {win_grp, 4'b0000};
    else if (grp_ok) begin
      for (int i = 0; i < NSRC; i++)
        if (SEL_W'(i) == sel_idx) cfg_rdata = {{(CFG_W-LVL_W){1'b0}}, levels[i]};
    end
  end

  assert_entry_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && grp_ok) |=> levels[$past(sel_idx)] == $past(cfg_wdata[LVL_W-1:0]));

  assert_window_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (cfg_rdata[3:0] == 4'b0 || cfg_sel) && win_grp == $past(cfg_wdata[7:4]));
endmodule

// File: rtl/ipc_winner_sel.sv
module ipc_winner_sel
  import ipc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int NSRC  = NUM_GROUPS * GRP_SZ,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   req,
  input  level_t [NSRC-1:0] levels,
  input  level_t            cur_level,
  input  logic              imask,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx,
  output level_t            win_level
);
  logic [NSRC-1:0]       elig;
  logic [NUM_GROUPS-1:0] g_valid;
  logic [2:0]            g_ent   [NUM_GROUPS];
  level_t                g_level [NUM_GROUPS];

  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    assign elig[i] = req[i] && !imask && (levels[i] != '0) && (levels[i] > cur_level);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_local
    always_comb begin
      g_valid[g] = 1'b0;
      g_ent[g]   = '0;
      g_level[g] = '0;
      for (int e = 0; e < GRP_SZ; e++) begin
        if (elig[g*GRP_SZ+e] && (!g_valid[g] || levels[g*GRP_SZ+e] >= g_level[g])) begin
          g_valid[g] = 1'b1;
          g_ent[g]   = 3'(e);
          g_level[g] = levels[g*GRP_SZ+e];
        end
      end
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_level = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (g_valid[g] && (!win_valid || g_level[g] >= win_level)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(g * GRP_SZ + int'(g_ent[g]));
        win_level = g_level[g];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import ipc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int VEC_W      = 8,
  localparam int NSRC  = NUM_GROUPS * GRP_SZ,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req_i,
  input  logic [2:0]       cur_level_i,
  input  logic             imask_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [2:0]       cfg_idx_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_rdata_o,
  output logic             irq_valid_o,
  input  logic             irq_ready_i,
  output logic [VEC_W-1:0] irq_vector_o,
  output logic [2:0]       irq_level_o,
  output logic             ack_stb_o,
  output logic [2:0]       ack_level_o
);
  level_t [NSRC-1:0] levels;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  level_t            win_level;
  logic              hs;
  logic [VEC_W-1:0]  win_vec;

  ipc_level_bank #(.NUM_GROUPS(NUM_GROUPS)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_i), .cfg_sel(cfg_sel_i),
    .cfg_idx(cfg_idx_i), .cfg_wdata(cfg_wdata_i), .cfg_rdata(cfg_rdata_o),
    .levels(levels)
  );

  ipc_winner_sel #(.NUM_GROUPS(NUM_GROUPS)) u_sel (
    .req(irq_req_i), .levels(levels), .cur_level(cur_level_i), .imask(imask_i),
    .win_valid(win_valid), .win_idx(win_idx), .win_level(win_level)
  );

  assign hs = irq_valid_o && irq_ready_i;

  always_comb begin
    win_vec = '0;
    win_vec[IDX_W:1] = win_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid_o  <= 1'b0;
      irq_vector_o <= '0;
      irq_level_o  <= '0;
      ack_stb_o    <= 1'b0;
      ack_level_o  <= '0;
    end else begin
      ack_stb_o <= hs;
      if (hs) ack_level_o <= irq_level_o;
      irq_valid_o  <= hs ? 1'b0 : win_valid;
      irq_vector_o <= win_vec;
      irq_level_o  <= win_level;
    end
  end

  assert_level_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> irq_level_o != 3'd0);

  assert_above_current_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> irq_level_o > $past(cur_level_i));

  assert_global_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(imask_i) |-> !irq_valid_o);

  assert_drop_after_hs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i) |=> !irq_valid_o);

  assert_ack_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i) |=> ack_stb_o && ack_level_o == $past(irq_level_o));

  assert_ack_only_after_hs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid_o && irq_ready_i) |=> !ack_stb_o);
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  localparam int NG = 4;
  localparam int NS = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] req = '0;
  logic [2:0]    cur = '0;
  logic          imask = 1'b0;
  logic          we = 1'b0, sel = 1'b0;
  logic [2:0]    idx = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          valid;
  logic          ready = 1'b0;
  logic [7:0]    vec;
  logic [2:0]    lvl;
  logic          ack_stb;
  logic [2:0]    ack_lvl;

  int nchk = 0, nfail = 0;
  int mdl [NS];
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NUM_GROUPS(NG)) i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .cur_level_i(cur), .imask_i(imask),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_idx_i(idx), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .irq_valid_o(valid), .irq_ready_i(ready),
    .irq_vector_o(vec), .irq_level_o(lvl), .ack_stb_o(ack_stb), .ack_level_o(ack_lvl)
  );

  task automatic chk(string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cfg_wr(logic s, logic [2:0] i, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; idx = i; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic cfg_rd(logic s, logic [2:0] i, string rq, int exp);
    @(negedge clk);
    sel = s; idx = i;
    #1;
    chk(rq, int'(rdata), exp);
  endtask

  task automatic set_lvl(int s, int l, logic [4:0] junk);
    cfg_wr(1'b0, 3'd0, 8'((s / 8) * 16) | 8'(junk[3:0]));
    cfg_wr(1'b1, 3'(s % 8), {junk, 3'(l)});
    mdl[s] = l;
  endtask

  task automatic apply(logic [NS-1:0] r, int c, logic m, string rq);
    int best = -1;
    @(negedge clk);
    req = r; cur = 3'(c); imask = m;
    @(posedge clk);
    #1;
    for (int i = 0; i < NS; i++)
      if (r[i] && !m && mdl[i] != 0 && mdl[i] > c && (best < 0 || mdl[i] >= mdl[best]))
        best = i;
    chk(rq, int'(valid), best >= 0 ? 1 : 0);
    if (best >= 0) begin
      chk(rq, int'(vec), 2 * best);
      chk(rq, int'(lvl), mdl[best]);
    end
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) mdl[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 valid", int'(valid), 0);
    cfg_rd(1'b0, 3'd0, "R1 window", 0);
    for (int s = 0; s < NS; s++) begin
      cfg_wr(1'b0, 3'd0, 8'((s / 8) * 16));
      cfg_rd(1'b1, 3'(s % 8), "R1 level", 1);
    end

    // R9: single requests, default levels
    for (int s = 0; s < NS; s++) apply(NS'(1) << s, 0, 1'b0, "R9 single");

    // R8: scattered levels, stray upper bits in the written data
    for (int s = 0; s < NS; s++) set_lvl(s, (s * 5 + 3) % 8, 5'(s + 7));
    for (int s = 0; s < NS; s++) begin
      cfg_wr(1'b0, 3'd0, 8'((s / 8) * 16 + 9));
      cfg_rd(1'b1, 3'(s % 8), "R8 readback", mdl[s]);
    end

    // R2: level-0 sources stay silent
    for (int s = 0; s < NS; s++) apply(NS'(1) << s, 0, 1'b0, "R2 single");

    // R3: many mixed patterns
    for (int p = 1; p < 80; p++) apply(NS'(p * 32'h9E3779B1), 0, 1'b0, "R3 mix");
    apply('1, 0, 1'b0, "R3 all");

    // R5: current level boundary
    for (int c = 0; c < 8; c++) begin
      apply('1, c, 1'b0, "R5 all");
      apply(NS'(32'h5A5A_C3C3), c, 1'b0, "R5 pattern");
    end

    // R6: global mask
    apply('1, 0, 1'b1, "R6 mask");
    apply(NS'(32'h0001_0000), 0, 1'b1, "R6 mask one");

    // R4: equal levels, higher address wins
    for (int s = 0; s < NS; s++) set_lvl(s, 4, 5'd0);
    for (int p = 1; p < 40; p++) apply(NS'(p * 32'h2545F491), 0, 1'b0, "R4 tie");
    apply(NS'(32'h0000_0101), 3, 1'b0, "R4 tie pair");

    // R7: window register and out-of-range group
    cfg_wr(1'b0, 3'd0, 8'h3B);
    cfg_rd(1'b0, 3'd0, "R7 window", 8'h30);
    cfg_wr(1'b0, 3'd0, 8'h57);
    cfg_wr(1'b1, 3'd2, 8'h06);
    cfg_rd(1'b1, 3'd2, "R7 out of range", 0);
    cfg_rd(1'b0, 3'd0, "R7 window hi", 8'h50);
    for (int g = 0; g < NG; g++) begin
      cfg_wr(1'b0, 3'd0, 8'(g * 16));
      cfg_rd(1'b1, 3'd2, "R7 untouched", 4);
    end

    // R10 / R11: handshake
    set_lvl(13, 6, 5'd0);
    apply('1, 0, 1'b0, "R10 offer");
    @(negedge clk);
    ready = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 drop", int'(valid), 0);
    chk("R11 strobe", int'(ack_stb), 1);
    chk("R11 level", int'(ack_lvl), 6);
    @(negedge clk);
    ready = 1'b0;
    @(posedge clk);
    #1;
    chk("R10 return", int'(valid), 1);
    chk("R10 vector", int'(vec), 26);
    chk("R11 strobe low", int'(ack_stb), 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule